// File: doc/BRIEF.md
# Filtered overflow-flagging event counter

This block is a single programmable hardware performance counter. Each cycle in which `event_pulse` is high, the counter adds one, unless one of three things blocks it. The slot's bit in the shared count-inhibit vector can block it. A per-privilege filter bit in the counter's selector word can block it. It is also blocked if the slot index is not a programmable slot. When the full count wraps from all ones to zero, a sticky overflow flag in the selector is set. A one-cycle interrupt request is raised only when that flag was clear before the wrap.

The count is held as two halves of `HALF_W` bits each. In wide mode (`mode32` low) the halves form one counter of `2*HALF_W` bits. In narrow mode (`mode32` high) the low half saturates at all ones and further events advance the high half. In both modes the control bits sit in the top six bits of the upper selector half. Software writes each half of the count and of the selector through its own write enable. All four halves are visible on the outputs.

Top module: `perf_event_counter`

## Requirements
- R1: Reset clears both count halves, both selector halves and `ovf_irq`.
- R2: In wide mode an unblocked event adds one to the count `{count_hi,count_lo}`, and the low half carries into the high half.
- R3: An event is ignored when `inhibit[SLOT_IDX]` is set, or when `SLOT_IDX` is below 3 or not below `NUM_SLOTS`.
- R4: Privilege is encoded as 2'b00 user, 2'b01 supervisor and 2'b11 machine. In machine mode, `sel_hi[HALF_W-2]` blocks counting.
- R5: In supervisor mode, `sel_hi[HALF_W-5]` blocks counting when `virt_on` is high, and `sel_hi[HALF_W-3]` blocks it when `virt_on` is low.
- R6: In user mode, `sel_hi[HALF_W-6]` blocks counting when `virt_on` is high, and `sel_hi[HALF_W-4]` blocks it when `virt_on` is low. The encoding 2'b10 is never filtered.
- R7: An unblocked event with both halves all ones clears both halves and sets the overflow flag `sel_hi[HALF_W-1]`.
- R8: `ovf_irq` is high for exactly one cycle, the cycle after a wrap that found the overflow flag clear. A wrap with the flag already set raises nothing.
- R9: In narrow mode the low half counts up to all ones. Later events add one to the high half while the low half stays at all ones.
- R10: In narrow mode a wrap happens only when both halves are all ones, and it clears both halves.
- R11: A count write in a cycle suppresses that cycle's event. A selector write wins over the overflow set. Only a selector write clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1 selects narrow (split-half) counting |
| priv | input | 2 | Current privilege mode |
| virt_on | input | 1 | Virtualisation active |
| event_pulse | input | 1 | One event in this cycle |
| inhibit | input | NUM_SLOTS | Count-inhibit vector, one bit per slot |
| cnt_lo_we | input | 1 | Write `cnt_wdata` to the low count half |
| cnt_hi_we | input | 1 | Write `cnt_wdata` to the high count half |
| cnt_wdata | input | HALF_W | Count write data |
| sel_lo_we | input | 1 | Write `sel_wdata` to the low selector half |
| sel_hi_we | input | 1 | Write `sel_wdata` to the high selector half |
| sel_wdata | input | HALF_W | Selector write data |
| count_lo | output | HALF_W | Low count half |
| count_hi | output | HALF_W | High count half |
| sel_lo | output | HALF_W | Low selector half |
| sel_hi | output | HALF_W | High selector half, control bits on top |
| ovf_irq | output | 1 | Overflow interrupt request pulse |

## Verification
The bench builds the counter with `HALF_W = 6`, which is the smallest width that still holds all six control bits. At that width a wide wrap takes 4096 events and a narrow wrap takes 127, so the bench can walk every count value up to and past each wrap. A second copy is built with `SLOT_IDX = 1` to show that an invalid slot never counts. The filter check covers all four privilege codes, both virtualisation states and all 32 filter patterns.

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
  parameter int HALF_W    = 32,
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_IDX  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode32,
  input  logic [1:0]           priv,
  input  logic                 virt_on,
  input  logic                 event_pulse,
  input  logic [NUM_SLOTS-1:0] inhibit,
  input  logic                 cnt_lo_we,
  input  logic                 cnt_hi_we,
  input  logic [HALF_W-1:0]    cnt_wdata,
  input  logic                 sel_lo_we,
  input  logic                 sel_hi_we,
  input  logic [HALF_W-1:0]    sel_wdata,
  output logic [HALF_W-1:0]    count_lo,
  output logic [HALF_W-1:0]    count_hi,
  output logic [HALF_W-1:0]    sel_lo,
  output logic [HALF_W-1:0]    sel_hi,
  output logic                 ovf_irq
);

  localparam int OF_B    = HALF_W - 1;
  localparam int MINH_B  = HALF_W - 2;
  localparam int SINH_B  = HALF_W - 3;
  localparam int UINH_B  = HALF_W - 4;
  localparam int VSINH_B = HALF_W - 5;
  localparam int VUINH_B = HALF_W - 6;
  localparam bit SLOT_OK = (SLOT_IDX >= 3) && (SLOT_IDX < NUM_SLOTS);
  localparam int INH_IDX = SLOT_OK ? SLOT_IDX : 0;

  logic [HALF_W-1:0] lo_q, hi_q, sello_q, selhi_q;
  logic              irq_q;
  logic              filt;

  wire of_q    = selhi_q[OF_B];
  wire cnt_wr  = cnt_lo_we | cnt_hi_we;
  wire lo_full = &lo_q;
  wire hi_full = &hi_q;

  always_comb begin
    case (priv)
      2'b11:   filt = selhi_q[MINH_B];
      2'b01:   filt = virt_on ? selhi_q[VSINH_B] : selhi_q[SINH_B];
      2'b00:   filt = virt_on ? selhi_q[VUINH_B] : selhi_q[UINH_B];
      default: filt = 1'b0;
    endcase
  end

  wire bump = SLOT_OK && event_pulse && !inhibit[INH_IDX] && !filt && !cnt_wr;
  wire wrap = bump && lo_full && hi_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      sello_q <= '0;
      selhi_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (cnt_lo_we) lo_q <= cnt_wdata;
      if (cnt_hi_we) hi_q <= cnt_wdata;
      if (bump) begin
        if (wrap) begin
          lo_q <= '0;
          hi_q <= '0;
        end else if (lo_full) begin
          hi_q <= hi_q + 1'b1;
          if (!mode32) lo_q <= '0;
        end else begin
          lo_q <= lo_q + 1'b1;
        end
      end
      if (sel_lo_we) sello_q <= sel_wdata;
      if (sel_hi_we) selhi_q <= sel_wdata;
      else if (wrap) selhi_q[OF_B] <= 1'b1;
      irq_q <= wrap && !of_q;
    end
  end

  assign count_lo = lo_q;
  assign count_hi = hi_q;
  assign sel_lo   = sello_q;
  assign sel_hi   = selhi_q;
  assign ovf_irq  = irq_q;

  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && !$past(sel_hi_we)) |-> sel_hi[OF_B]); // R8
  AST_IRQ_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> !$past(sel_hi[OF_B])); // R8
  AST_INHIBIT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit[INH_IDX] && !cnt_lo_we && !cnt_hi_we) |=> ($stable(count_lo) && $stable(count_hi))); // R3
  AST_MACHINE_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'b11 && sel_hi[MINH_B] && !cnt_lo_we && !cnt_hi_we) |=> ($stable(count_lo) && $stable(count_hi))); // R4
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count_lo == '0 && count_hi == '0)); // R7
  AST_NARROW_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && mode32 && lo_full && !hi_full) |=> (&count_lo && count_hi == HALF_W'($past(count_hi) + 1'b1))); // R9
  AST_COUNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lo_we |=> count_lo == $past(cnt_wdata)); // R11

endmodule

// File: tb/test_perf_event_counter.sv
module test_perf_event_counter;
  localparam int HW   = 6;
  localparam int FULL = 1 << (2 * HW);
  localparam int NPER = 2 * ((1 << HW) - 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode32 = 1'b0;
  logic [1:0] priv = 2'b11;
  logic virt_on = 1'b0;
  logic event_pulse = 1'b0;
  logic [31:0] inhibit = '0;
  logic cnt_lo_we = 1'b0, cnt_hi_we = 1'b0, sel_lo_we = 1'b0, sel_hi_we = 1'b0;
  logic [HW-1:0] cnt_wdata = '0, sel_wdata = '0;
  logic [HW-1:0] count_lo, count_hi, sel_lo, sel_hi;
  logic [HW-1:0] bad_lo, bad_hi, bad_slo, bad_shi;
  logic ovf_irq, bad_irq;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  perf_event_counter #(.HALF_W(HW), .NUM_SLOTS(32), .SLOT_IDX(3)) i_perf_event_counter (
    .clk(clk), .rst_n(rst_n), .mode32(mode32), .priv(priv), .virt_on(virt_on),
    .event_pulse(event_pulse), .inhibit(inhibit), .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
    .cnt_wdata(cnt_wdata), .sel_lo_we(sel_lo_we), .sel_hi_we(sel_hi_we), .sel_wdata(sel_wdata),
    .count_lo(count_lo), .count_hi(count_hi), .sel_lo(sel_lo), .sel_hi(sel_hi), .ovf_irq(ovf_irq));

  perf_event_counter #(.HALF_W(HW), .NUM_SLOTS(32), .SLOT_IDX(1)) i_bad_slot (
    .clk(clk), .rst_n(rst_n), .mode32(mode32), .priv(priv), .virt_on(virt_on),
    .event_pulse(event_pulse), .inhibit(inhibit), .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
    .cnt_wdata(cnt_wdata), .sel_lo_we(sel_lo_we), .sel_hi_we(sel_hi_we), .sel_wdata(sel_wdata),
    .count_lo(bad_lo), .count_hi(bad_hi), .sel_lo(bad_slo), .sel_hi(bad_shi), .ovf_irq(bad_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire();
    event_pulse = 1'b1;
    @(negedge clk);
    event_pulse = 1'b0;
  endtask

  task automatic wr_lo(input logic [HW-1:0] v);
    cnt_lo_we = 1'b1; cnt_wdata = v; @(negedge clk); cnt_lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [HW-1:0] v);
    cnt_hi_we = 1'b1; cnt_wdata = v; @(negedge clk); cnt_hi_we = 1'b0;
  endtask

  task automatic wr_shi(input logic [HW-1:0] v);
    sel_hi_we = 1'b1; sel_wdata = v; @(negedge clk); sel_hi_we = 1'b0;
  endtask

  function automatic string ftag(input int p);
    if (p == 3) return "R4";
    if (p == 1) return "R5";
    return "R6";
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", 32'({count_hi, count_lo}), 0);
    chk("R1 sel", 32'({sel_hi, sel_lo}), 0);
    chk("R1 irq", 32'(ovf_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 1; n <= FULL + 3; n++) begin
      fire();
      chk("R2 wide count", 32'({count_hi, count_lo}), 32'(n % FULL));
      chk("R8 irq", 32'(ovf_irq), 32'(n == FULL));
      if (n == FULL) chk("R7 flag set", 32'(sel_hi[HW-1]), 1);
    end

    wr_lo('1); wr_hi('1);
    fire();
    chk("R7 second wrap", 32'({count_hi, count_lo}), 0);
    chk("R8 no irq with flag set", 32'(ovf_irq), 0);

    wr_shi('0);
    chk("R11 flag cleared by write", 32'(sel_hi), 0);
    wr_lo('1); wr_hi('1);
    event_pulse = 1'b1; sel_hi_we = 1'b1; sel_wdata = '0;
    @(negedge clk);
    event_pulse = 1'b0; sel_hi_we = 1'b0;
    chk("R7 wrap with sel write", 32'({count_hi, count_lo}), 0);
    chk("R11 sel write beats flag", 32'(sel_hi), 0);
    chk("R8 irq from clear flag", 32'(ovf_irq), 1);
    repeat (3) @(negedge clk);
    chk("R8 irq single cycle", 32'(ovf_irq), 0);
    chk("R11 flag stays clear", 32'(sel_hi[HW-1]), 0);

    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 2; v++) begin
        for (int f = 0; f < 32; f++) begin
          bit blk;
          priv = 2'(p); virt_on = v[0];
          wr_lo('0); wr_hi('0); wr_shi(6'(f));
          fire();
          case (p)
            3: blk = f[4];
            1: blk = v[0] ? f[1] : f[3];
            0: blk = v[0] ? f[0] : f[2];
            default: blk = 1'b0;
          endcase
          chk(ftag(p), 32'(count_lo), blk ? 0 : 1);
        end
      end
    end
    priv = 2'b11; virt_on = 1'b0;
    wr_shi('0);

    inhibit = 32'h8;
    wr_lo('0); wr_hi('0);
    fire(); fire(); fire();
    chk("R3 inhibited", 32'(count_lo), 0);
    inhibit = ~32'h8;
    fire();
    chk("R3 other bits", 32'(count_lo), 1);
    inhibit = '0;
    wr_lo('0); wr_hi('0);
    repeat (5) fire();
    chk("R3 invalid slot", 32'({bad_hi, bad_lo}), 0);
    chk("R2 valid slot", 32'({count_hi, count_lo}), 5);

    cnt_lo_we = 1'b1; cnt_wdata = 6'd20; event_pulse = 1'b1;
    @(negedge clk);
    cnt_lo_we = 1'b0; event_pulse = 1'b0;
    chk("R11 count write wins", 32'({count_hi, count_lo}), 20);

    mode32 = 1'b1;
    wr_lo('0); wr_hi('0);
    for (int n = 1; n <= 300; n++) begin
      int m;
      m = n % NPER;
      fire();
      if (m == 0) begin
        chk("R10 narrow wrap", 32'({count_hi, count_lo}), 0);
      end else begin
        chk("R9 low", 32'(count_lo), (m < 63) ? m : 63);
        chk("R9 high", 32'(count_hi), (m < 63) ? 0 : m - 63);
      end
      chk("R8 narrow irq", 32'(ovf_irq), 32'(n == NPER));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule